// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core with Hold Handshake

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours, weekday, day of month, month and a two-digit year covering 2000 to 2099. It runs from a slow tick strobe, normally 32.768 kHz, and advances one second after every `TICKS_PER_SEC` tick pulses. Counting happens only while the counter-enable control bit is set and no hold is active. Seconds carry into minutes, minutes into hours, and hours into the day. Day rollover follows month lengths and leap years. The weekday wraps from 6 to 0 at midnight. Hours always count in 24-hour form.

Software talks to the core through a byte-wide register port. Writes take effect at once. Reads are registered and appear on `rdata` one cycle after `rd_en`. There are two banks of time registers. The writable bank holds values waiting to be loaded. The read-only live bank shows the running counters.

To set the time, software writes the hold request bit. It then waits for the stopped-status bit, writes the fields it wants to change, and writes zero to release the hold. On release, all fields are loaded into the counters together. The hold sequencer has four states:
- RUN: counting is allowed.
- SYNC1 and SYNC2: one tick pulse spent in each.
- HELD: the counter is stopped.

Its transitions are:
- A request write moves RUN to SYNC1.
- Each tick pulse moves SYNC1 to SYNC2, and SYNC2 to HELD.
- A zero write to the hold register moves any of SYNC1, SYNC2 or HELD back to RUN and loads the counters.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, the live bank reads second 0x00, minute 0x00, hour 0x00, weekday 0x06, day 0x01, month 0x01 and year 0x00. The control register at 0x00 reads 0x00, and the hold register at 0x08 reads 0x00.
- R2: In the control register at 0x00, bit 7 enables counting and bit 5 selects 24-hour mode. Only these two bits are stored, and all other bits read 0. Bit 5 does not change how hours count. While bit 7 is 0, tick pulses do not advance the time.
- R3: While counting is enabled and no hold is active, the seconds field advances by one on the `TICKS_PER_SEC`-th tick pulse, and not before.
- R4: Writing 1 to bit 0 of the hold register at 0x08 sets bit 0 (hold requested) in the next cycle. Bit 1 (stopped) sets after exactly two further tick pulses.
- R5: While bit 0 or bit 1 of the hold register is set, the live counters do not advance.
- R6: The writable bank sits at 0x14, 0x18, 0x1C, 0x20, 0x24, 0x28 and 0x2C, in the order second, minute, hour, weekday, day, month, year. These registers accept writes only while a hold is active. A write made while running is ignored and reads back the previous value.
- R7: Writing 0 to the hold register clears both status bits. It copies the writable bank into the live counters and starts a fresh second, so `TICKS_PER_SEC` tick pulses are needed before the next advance.
- R8: The live bank sits at 0x4C to 0x64 with the same order and 4-byte stride. Writes to it have no effect.
- R9: Second 59 wraps to 00 and carries into the minute. Minute 59 wraps and carries into the hour. Hour 23 wraps to 00, advances the day, and moves the weekday up by one, with 6 wrapping to 0. BCD digit carries such as 09 to 10 are exact.
- R10: Day rolls to 01 and the month advances after day 30 in April, June, September and November, and after day 31 in the other long months. Month 12 wraps to 01 and advances the year.
- R11: February ends at day 28, or at day 29 when the year value is divisible by 4. Year 99 wraps to 00.
- R12: When a hold begins, the writable bank captures the live time. Fields not written during the hold keep that captured value after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe from the 32.768 kHz timebase |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data on `rdata` next cycle |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
The time is loaded to sit just before a series of boundaries:
- a plain seconds step;
- BCD digit carries in the minute and hour;
- a full end-of-century rollover through every field;
- the end of a 30-day month and of a 31-day month;
- the end of February in a leap year and in a common year.

Each case tells apart a different limit in the carry chain, such as a 30-day versus a 31-day limit, or a leap-year versus a common-year February, and shows whether the weekday and year wrap.

Tick pulses are counted one at a time around the enable bit, the hold request and the release. This shows whether the stop status needs exactly two pulses, and whether counting restarts from a fresh second. Writes made while running, and partial writes made while held, show whether the ignore rule and the capture on hold entry work.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NUM_FIELDS = 7;
    localparam int REG_STRIDE = 4;

    localparam int CTRL_OFS   = 'h00;
    localparam int HOLD_OFS   = 'h08;
    localparam int SET_BASE   = 'h14;
    localparam int LIVE_BASE  = 'h4C;

    localparam int EN_BIT     = 7;
    localparam int H24_BIT    = 5;
    localparam int REQ_BIT    = 0;
    localparam int STOP_BIT   = 1;

    typedef enum logic [2:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_WDAY = 3'd3,
        F_DAY  = 3'd4,
        F_MON  = 3'd5,
        F_YEAR = 3'd6
    } field_e;

    typedef logic [7:0] bcd8_t;
    typedef bcd8_t [NUM_FIELDS-1:0] cal_vec_t;

    typedef enum logic [1:0] {
        HS_RUN   = 2'd0,
        HS_SYNC1 = 2'd1,
        HS_SYNC2 = 2'd2,
        HS_HELD  = 2'd3
    } hold_state_e;

    // year 00, month 01, day 01, weekday 6, 00:00:00
    localparam cal_vec_t CAL_RESET = {8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00};

    function automatic bcd8_t bcd_inc(input bcd8_t v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_to_bin(input bcd8_t v);
        return (7'(v[7:4]) * 7'd10) + 7'(v[3:0]);
    endfunction

    function automatic logic year_is_leap(input bcd8_t yr);
        logic [6:0] b;
        b = bcd_to_bin(yr);
        return (b[1:0] == 2'b00);
    endfunction

    function automatic bcd8_t month_last_day(input bcd8_t mon, input bcd8_t yr);
        bcd8_t last;
        case (mon)
            8'h02:                     last = year_is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last = 8'h30;
            default:                   last = 8'h31;
        endcase
        return last;
    endfunction

endpackage

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic restart,
    output logic sec_pulse
);
    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            if (cnt_q == LAST)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sec_pulse = run && tick && (cnt_q == LAST);

    // R3: the tick count never passes the per-second limit
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3: a seconds pulse always leaves the count at zero
    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> (cnt_q == '0));

    // R5: while not running and not restarted, the count holds
    assert_frozen_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_hold_fsm.sv
module rtc_hold_fsm
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold_wr,
    input  logic hold_req,
    output logic wait_flag,
    output logic stop_flag,
    output logic capture,
    output logic release_load
);
    hold_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_RUN: begin
                if (hold_wr && hold_req)
                    state_d = HS_SYNC1;
            end
            HS_SYNC1: begin
                if (hold_wr && !hold_req)
                    state_d = HS_RUN;
                else if (tick)
                    state_d = HS_SYNC2;
            end
            HS_SYNC2: begin
                if (hold_wr && !hold_req)
                    state_d = HS_RUN;
                else if (tick)
                    state_d = HS_HELD;
            end
            HS_HELD: begin
                if (hold_wr && !hold_req)
                    state_d = HS_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= HS_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        wait_flag    = 1'b0;
        stop_flag    = 1'b0;
        capture      = 1'b0;
        release_load = 1'b0;
        unique case (state_q)
            HS_RUN: begin
                capture = hold_wr && hold_req;
            end
            HS_SYNC1, HS_SYNC2: begin
                wait_flag    = 1'b1;
                release_load = hold_wr && !hold_req;
            end
            HS_HELD: begin
                wait_flag    = 1'b1;
                stop_flag    = 1'b1;
                release_load = hold_wr && !hold_req;
            end
        endcase
    end

    // R4: the stopped status only appears on a tick out of the second sync state
    assert_stop_after_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_flag) |-> ($past(tick) && $past(state_q == HS_SYNC2)));

    // R4: a request raises the hold flag on the next cycle
    assert_req_raises_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (wait_flag && !stop_flag));

    // R7: the hold flag only drops through a release write
    assert_release_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_flag) |-> $past(release_load));

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_cal_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sec_pulse,
    input  logic     load,
    input  cal_vec_t load_val,
    output cal_vec_t live
);
    cal_vec_t cur_q, inc_d;
    logic     c_min, c_hour, c_day, c_mon, c_year;

    always_comb begin
        inc_d  = cur_q;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;

        if (cur_q[F_SEC] == 8'h59) begin
            inc_d[F_SEC] = 8'h00;
            c_min        = 1'b1;
        end else begin
            inc_d[F_SEC] = bcd_inc(cur_q[F_SEC]);
        end

        if (c_min) begin
            if (cur_q[F_MIN] == 8'h59) begin
                inc_d[F_MIN] = 8'h00;
                c_hour       = 1'b1;
            end else begin
                inc_d[F_MIN] = bcd_inc(cur_q[F_MIN]);
            end
        end

        if (c_hour) begin
            if (cur_q[F_HOUR] == 8'h23) begin
                inc_d[F_HOUR] = 8'h00;
                c_day         = 1'b1;
            end else begin
                inc_d[F_HOUR] = bcd_inc(cur_q[F_HOUR]);
            end
        end

        if (c_day) begin
            inc_d[F_WDAY] = (cur_q[F_WDAY] == 8'h06) ? 8'h00 : (cur_q[F_WDAY] + 8'h01);
            if (cur_q[F_DAY] == month_last_day(cur_q[F_MON], cur_q[F_YEAR])) begin
                inc_d[F_DAY] = 8'h01;
                c_mon        = 1'b1;
            end else begin
                inc_d[F_DAY] = bcd_inc(cur_q[F_DAY]);
            end
        end

        if (c_mon) begin
            if (cur_q[F_MON] == 8'h12) begin
                inc_d[F_MON] = 8'h01;
                c_year       = 1'b1;
            end else begin
                inc_d[F_MON] = bcd_inc(cur_q[F_MON]);
            end
        end

        if (c_year)
            inc_d[F_YEAR] = (cur_q[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cur_q[F_YEAR]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= CAL_RESET;
        else if (load)
            cur_q <= load_val;
        else if (sec_pulse)
            cur_q <= inc_d;
    end

    assign live = cur_q;

    // R5: without a seconds pulse or a load, no field moves
    assert_time_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_pulse && !load) |=> $stable(cur_q));

    // R9: a counted second keeps the seconds field a valid BCD value below 60
    assert_sec_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sec_pulse && !load) |-> (cur_q[F_SEC] < 8'h60 && cur_q[F_SEC][3:0] < 4'd10));

    // R9: weekday stays within 0..6 after a counted second
    assert_wday_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sec_pulse && !load) |-> (cur_q[F_WDAY] <= 8'h06));

    // R10: the day never passes the month's last day after counting
    assert_day_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sec_pulse && !load) |->
            (cur_q[F_DAY] >= 8'h01 && cur_q[F_DAY] <= month_last_day(cur_q[F_MON], cur_q[F_YEAR])));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int ADDR_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] HOLD_A = ADDR_W'(HOLD_OFS);

    logic     en_q, h24_q;
    logic     wait_flag, stop_flag, capture, release_load;
    logic     hold_wr, run, sec_pulse;
    cal_vec_t shadow_q, live;
    logic [NUM_FIELDS-1:0] set_hit, live_hit;
    logic [7:0] rd_mux;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_decode
            assign set_hit[gi]  = (addr == ADDR_W'(SET_BASE  + REG_STRIDE * gi));
            assign live_hit[gi] = (addr == ADDR_W'(LIVE_BASE + REG_STRIDE * gi));
        end
    endgenerate

    assign hold_wr = wr_en && (addr == HOLD_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            h24_q <= 1'b0;
        end else if (wr_en && addr == CTRL_A) begin
            en_q  <= wdata[EN_BIT];
            h24_q <= wdata[H24_BIT];
        end
    end

    rtc_hold_fsm u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .hold_wr      (hold_wr),
        .hold_req     (wdata[REQ_BIT]),
        .wait_flag    (wait_flag),
        .stop_flag    (stop_flag),
        .capture      (capture),
        .release_load (release_load)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= CAL_RESET;
        end else if (capture) begin
            shadow_q <= live;
        end else if (wr_en && wait_flag) begin
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (set_hit[i])
                    shadow_q[i] <= wdata;
            end
        end
    end

    assign run = en_q && !wait_flag && !capture;

    rtc_sec_prescaler #(
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (run),
        .restart   (release_load),
        .sec_pulse (sec_pulse)
    );

    rtc_time_chain u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_pulse (sec_pulse),
        .load      (release_load),
        .load_val  (shadow_q),
        .live      (live)
    );

    always_comb begin
        rd_mux = 8'h00;
        if (addr == CTRL_A) begin
            rd_mux[EN_BIT]  = en_q;
            rd_mux[H24_BIT] = h24_q;
        end else if (addr == HOLD_A) begin
            rd_mux[REQ_BIT]  = wait_flag;
            rd_mux[STOP_BIT] = stop_flag;
        end
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (set_hit[i])
                rd_mux = shadow_q[i];
            if (live_hit[i])
                rd_mux = live[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= 8'h00;
        else if (rd_en)
            rdata <= rd_mux;
    end

    // R6: a time-register write while running leaves the writable bank untouched
    assert_ignore_running_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wait_flag && addr != HOLD_A) |=> $stable(shadow_q));

    // R2: with counting disabled, a tick moves no live field
    assert_disabled_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !release_load) |=> $stable(live));

    // R7: a release makes the live bank equal to the loaded values
    assert_release_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        release_load |=> (live == $past(shadow_q)));

endmodule

// File: tb/rtc_calendar_core_tb.sv
`timescale 1ns/1ps
module rtc_calendar_core_tb;
    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] a;
        string      tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #2 clk = ~clk;

    rtc_calendar_core #(.TICKS_PER_SEC(TPS), .ADDR_W(8)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    // monitor: pops an expected item for every read strobe seen at an edge
    always @(posedge clk) begin
        if (rd_en) begin
            #1;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                n_tests++;
                if (rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr=0x%02h actual=0x%02h expected=0x%02h",
                             it.tag, it.a, rdata, it.exp);
                end
            end
        end
    end

    task automatic rd_expect(input logic [7:0] a, input logic [7:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        it.exp = e; it.a = a; it.tag = tag;
        sb_q.push_back(it);
        addr  = a;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic give_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                            input logic [7:0] y);
        wr(8'h08, 8'h01);
        give_ticks(2);
        wr(8'h14, s);  wr(8'h18, m);  wr(8'h1C, h);
        wr(8'h20, w);  wr(8'h24, d);  wr(8'h28, mo); wr(8'h2C, y);
        wr(8'h08, 8'h00);
    endtask

    task automatic expect_live(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                               input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                               input logic [7:0] y, input string tag);
        rd_expect(8'h4C, s,  {tag, " sec"});
        rd_expect(8'h50, m,  {tag, " min"});
        rd_expect(8'h54, h,  {tag, " hour"});
        rd_expect(8'h58, w,  {tag, " wday"});
        rd_expect(8'h5C, d,  {tag, " day"});
        rd_expect(8'h60, mo, {tag, " month"});
        rd_expect(8'h64, y,  {tag, " year"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        expect_live(8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00, "R1 reset");
        rd_expect(8'h00, 8'h00, "R1 ctrl reset");
        rd_expect(8'h08, 8'h00, "R1 hold reset");

        // R2: ticks with counting disabled do nothing
        give_ticks(8);
        rd_expect(8'h4C, 8'h00, "R2 disabled no count");
        wr(8'h00, 8'hA1);
        rd_expect(8'h00, 8'hA0, "R2 ctrl readback");

        // R3: exactly TPS pulses per second
        give_ticks(TPS - 1);
        rd_expect(8'h4C, 8'h00, "R3 before last tick");
        give_ticks(1);
        rd_expect(8'h4C, 8'h01, "R3 after last tick");

        // R6, R8: writes while running are ignored
        wr(8'h14, 8'h33);
        rd_expect(8'h14, 8'h00, "R6 running write ignored");
        wr(8'h4C, 8'h55);
        rd_expect(8'h4C, 8'h01, "R8 live bank read-only");

        // R4: hold handshake, R5: frozen while held, R12: capture
        wr(8'h08, 8'h01);
        rd_expect(8'h08, 8'h01, "R4 request flag");
        give_ticks(1);
        rd_expect(8'h08, 8'h01, "R4 one tick not stopped");
        give_ticks(1);
        rd_expect(8'h08, 8'h03, "R4 stopped after two ticks");
        give_ticks(3 * TPS);
        rd_expect(8'h4C, 8'h01, "R5 no count while held");
        rd_expect(8'h14, 8'h01, "R12 capture on hold");

        // R7 + R9/R10/R11: full rollover at end of century
        wr(8'h14, 8'h59); wr(8'h18, 8'h59); wr(8'h1C, 8'h23); wr(8'h20, 8'h06);
        wr(8'h24, 8'h31); wr(8'h28, 8'h12); wr(8'h2C, 8'h99);
        wr(8'h08, 8'h00);
        rd_expect(8'h08, 8'h00, "R7 release clears status");
        rd_expect(8'h4C, 8'h59, "R7 loaded value");
        give_ticks(TPS - 1);
        rd_expect(8'h4C, 8'h59, "R7 fresh second");
        give_ticks(1);
        expect_live(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, "R9 R10 R11 century rollover");

        // R9: BCD digit carries
        set_time(8'h59, 8'h09, 8'h09, 8'h02, 8'h15, 8'h07, 8'h23);
        give_ticks(TPS);
        rd_expect(8'h50, 8'h10, "R9 minute digit carry");
        set_time(8'h59, 8'h59, 8'h09, 8'h02, 8'h15, 8'h07, 8'h23);
        give_ticks(TPS);
        rd_expect(8'h54, 8'h10, "R9 hour digit carry");

        // R10: 30-day and 31-day months
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h25);
        give_ticks(TPS);
        rd_expect(8'h5C, 8'h01, "R10 april end day");
        rd_expect(8'h60, 8'h05, "R10 april end month");
        rd_expect(8'h58, 8'h04, "R9 weekday step");
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h25);
        give_ticks(TPS);
        rd_expect(8'h5C, 8'h31, "R10 january has 31");

        // R11: February
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
        give_ticks(TPS);
        rd_expect(8'h5C, 8'h01, "R11 common feb day");
        rd_expect(8'h60, 8'h03, "R11 common feb month");
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
        give_ticks(TPS);
        rd_expect(8'h5C, 8'h29, "R11 leap feb 29");
        give_ticks(24 * 3600 * TPS > 0 ? 0 : 0);
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
        give_ticks(TPS);
        rd_expect(8'h5C, 8'h01, "R11 leap feb end day");
        rd_expect(8'h60, 8'h03, "R11 leap feb end month");

        // R12: partial write during hold
        set_time(8'h30, 8'h20, 8'h10, 8'h01, 8'h05, 8'h06, 8'h40);
        wr(8'h08, 8'h01);
        give_ticks(2);
        wr(8'h18, 8'h45);
        wr(8'h08, 8'h00);
        rd_expect(8'h4C, 8'h30, "R12 unwritten sec kept");
        rd_expect(8'h50, 8'h45, "R12 written min");
        rd_expect(8'h54, 8'h10, "R12 unwritten hour kept");

        // R2: 24-hour bit has no effect on hour counting
        wr(8'h00, 8'h80);
        set_time(8'h59, 8'h59, 8'h12, 8'h01, 8'h05, 8'h06, 8'h40);
        give_ticks(TPS);
        rd_expect(8'h54, 8'h13, "R2 hour past 12");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule